// File: doc/BRIEF.md
# Deferred Exception Token Tracker

This block is the register file and execute-stage controller for control speculation. Each general register holds a data word plus a one-bit poison token. Speculative loads that hit a memory fault do not trap. They mark their destination as poisoned instead. The poison then travels through computation along the dependency chain. A later speculation check looks at one register and, if the token is set, asks the front end to branch to recovery code rather than raising a trap.

The block accepts one decoded operation per cycle, qualified by a valid bit. The operations are a normal load, a speculative load, a two-source ALU operation, a speculation check, a store, or no operation. Memory read data and a fault flag arrive in the same cycle as the load. The store address, store data and write enable are combinational outputs in that same cycle. Register write-back information, the redirect request and the exception request are registered and appear in the cycle after the operation is accepted. Each of these lasts one cycle.

Top module: `dtt_core`

## Requirements
- R1: After synchronous reset (`rst` high), every register token is clear, and `wb_valid`, `redirect` and `raise_exc` are low.
- R2: A normal load (op_kind 1) whose address register is clean and whose `mem_fault` is high raises `raise_exc` with `exc_cause` 1 in the next cycle. It writes no register.
- R3: A speculative load (op_kind 2) with `mem_fault` high raises no exception. It writes `rd` with the token set.
- R4: An ALU operation (op_kind 3) sets the destination token when either source token is set. Only a speculative load or an ALU operation ever produces a write-back with the token set.
- R5: A load, speculative load or ALU operation whose sources are all clean and that sees no fault writes its data and clears the destination token. Load data is `mem_rdata`. ALU codes in `alu_fn` are 0 add, 1 subtract (rs1 minus rs2), 2 AND, 3 XOR.
- R6: A check (op_kind 4) on a clean `rs1` does nothing. On a poisoned `rs1` it pulses `redirect` in the next cycle, with `redirect_pc` equal to `pc` plus the sign-extended `imm`. It never writes a register or raises an exception.
- R7: A store (op_kind 5) with either source poisoned keeps `mem_we` low and raises `exc_cause` 2 in the next cycle. A clean store drives `mem_we` high in the same cycle, with `mem_addr` equal to rs1 plus the sign-extended `imm` and `mem_wdata` equal to rs2.
- R8: Register 0 reads as zero with a clear token, and writes to it are dropped. No write-back is reported for index 0.
- R9: An operation presented with `op_valid` low has no effect on state or outputs. Op codes 0, 6 and 7 behave as no operation.
- R10: A normal load with a poisoned address register raises `exc_cause` 2 and writes nothing. A speculative load with a poisoned address register writes `rd` with the token set, whatever the state of `mem_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_kind | input | 3 | 0 none, 1 load, 2 speculative load, 3 ALU, 4 check, 5 store |
| alu_fn | input | 2 | ALU function code |
| rd | input | 4 | Destination register index |
| rs1 | input | 4 | First source (address base or checked register) |
| rs2 | input | 4 | Second source (ALU operand or store data) |
| imm | input | 12 | Signed immediate (address or branch offset) |
| pc | input | 32 | Address of the current operation |
| mem_rdata | input | 64 | Load data from memory |
| mem_fault | input | 1 | Memory fault for this cycle's load |
| mem_addr | output | 64 | Memory address |
| mem_wdata | output | 64 | Store data |
| mem_we | output | 1 | Store write enable |
| wb_valid | output | 1 | A register was written in the previous cycle |
| wb_idx | output | 4 | Written register index |
| wb_data | output | 64 | Written data |
| wb_tok | output | 1 | Written token |
| redirect | output | 1 | Branch-to-recovery request pulse |
| redirect_pc | output | 32 | Redirect target |
| raise_exc | output | 1 | Exception request pulse |
| exc_cause | output | 2 | 1 load fault, 2 poison consumed |

## Verification
The bench keeps the default parameters: 16 registers, a 64-bit data word, a 12-bit immediate and a 32-bit pc. With only 16 registers, random destinations and sources collide often, so poison chains several operations deep build up and are later hit by checks and stores. The 12-bit immediate makes both negative and positive redirect offsets likely. Register 0 is drawn as a source and as a destination often enough to exercise its special case throughout the run.

// File: rtl/dtt_pkg.sv
package dtt_pkg;

    typedef enum logic [2:0] {
        OPK_NONE  = 3'd0,
        OPK_LOAD  = 3'd1,
        OPK_SLOAD = 3'd2,
        OPK_ALU   = 3'd3,
        OPK_CHECK = 3'd4,
        OPK_STORE = 3'd5
    } opk_e;

    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_SUB = 2'd1,
        FN_AND = 2'd2,
        FN_XOR = 2'd3
    } alufn_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_LDFLT  = 2'd1,
        CAUSE_POISON = 2'd2
    } cause_e;

    typedef struct packed {
        logic   redir;
        logic   exc;
        cause_e cause;
        logic   st_we;
        logic   wr_en;
        logic   wr_tok;
    } ctl_s;

endpackage

// File: rtl/dtt_regfile.sv
module dtt_regfile #(
    parameter int NREG   = 16,
    parameter int DATA_W = 64,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [DATA_W-1:0] ra_data,
    output logic              ra_tok,
    output logic [DATA_W-1:0] rb_data,
    output logic              rb_tok,
    input  logic              w_en,
    input  logic [IDX_W-1:0]  w_idx,
    input  logic [DATA_W-1:0] w_data,
    input  logic              w_tok
);
    logic [DATA_W-1:0] data_q [NREG];
    logic              tok_q  [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == 0) begin : g_zero
            always_ff @(posedge clk) begin
                data_q[i] <= '0;
                tok_q[i]  <= 1'b0;
            end
        end else begin : g_live
            always_ff @(posedge clk) begin
                if (rst) begin
                    data_q[i] <= '0;
                    tok_q[i]  <= 1'b0;
                end else if (w_en && w_idx == IDX_W'(i)) begin
                    data_q[i] <= w_data;
                    tok_q[i]  <= w_tok;
                end
            end
        end
    end

    assign ra_data = data_q[ra_idx];
    assign ra_tok  = tok_q[ra_idx];
    assign rb_data = data_q[rb_idx];
    assign rb_tok  = tok_q[rb_idx];

    // R8: the zero register must never report a token
    always_comb begin
        if (!rst) assert_r0_clean_R8: assert (ra_idx != '0 || !ra_tok);
    end
endmodule

// File: rtl/dtt_exec.sv
module dtt_exec
    import dtt_pkg::*;
#(
    parameter int NREG   = 16,
    parameter int DATA_W = 64,
    parameter int IMM_W  = 12,
    parameter int PC_W   = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              op_valid,
    input  logic [2:0]        op_kind,
    input  logic [1:0]        alu_fn,
    input  logic [IDX_W-1:0]  rd,
    input  logic [IMM_W-1:0]  imm,
    input  logic [PC_W-1:0]   pc,
    input  logic [DATA_W-1:0] a_data,
    input  logic              a_tok,
    input  logic [DATA_W-1:0] b_data,
    input  logic              b_tok,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_fault,
    output ctl_s              ctl,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] mem_addr,
    output logic [PC_W-1:0]   redir_pc
);
    logic [DATA_W-1:0] imm_d;
    logic [PC_W-1:0]   imm_p;
    logic [DATA_W-1:0] alu_res;
    logic              rd_live;

    assign imm_d    = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
    assign imm_p    = {{(PC_W-IMM_W){imm[IMM_W-1]}}, imm};
    assign mem_addr = a_data + imm_d;
    assign redir_pc = pc + imm_p;
    assign rd_live  = (rd != '0);

    always_comb begin
        unique case (alufn_e'(alu_fn))
            FN_ADD:  alu_res = a_data + b_data;
            FN_SUB:  alu_res = a_data - b_data;
            FN_AND:  alu_res = a_data & b_data;
            default: alu_res = a_data ^ b_data;
        endcase
    end

    always_comb begin
        ctl     = '0;
        wr_data = '0;
        if (op_valid) begin
            case (opk_e'(op_kind))
                OPK_LOAD: begin
                    if (a_tok) begin
                        ctl.exc   = 1'b1;
                        ctl.cause = CAUSE_POISON;
                    end else if (mem_fault) begin
                        ctl.exc   = 1'b1;
                        ctl.cause = CAUSE_LDFLT;
                    end else begin
                        ctl.wr_en = rd_live;
                        wr_data   = mem_rdata;
                    end
                end
                OPK_SLOAD: begin
                    ctl.wr_en  = rd_live;
                    ctl.wr_tok = a_tok | mem_fault;
                    wr_data    = (a_tok | mem_fault) ? '0 : mem_rdata;
                end
                OPK_ALU: begin
                    ctl.wr_en  = rd_live;
                    ctl.wr_tok = a_tok | b_tok;
                    wr_data    = (a_tok | b_tok) ? '0 : alu_res;
                end
                OPK_CHECK: ctl.redir = a_tok;
                OPK_STORE: begin
                    if (a_tok | b_tok) begin
                        ctl.exc   = 1'b1;
                        ctl.cause = CAUSE_POISON;
                    end else begin
                        ctl.st_we = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R6: a check never writes or traps in the same decision
    always_comb begin
        assert_chk_quiet_R6: assert (!ctl.redir || (!ctl.wr_en && !ctl.exc && !ctl.st_we));
    end
endmodule

// File: rtl/dtt_core.sv
module dtt_core
    import dtt_pkg::*;
#(
    parameter int NREG   = 16,
    parameter int DATA_W = 64,
    parameter int IMM_W  = 12,
    parameter int PC_W   = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [2:0]        op_kind,
    input  logic [1:0]        alu_fn,
    input  logic [IDX_W-1:0]  rd,
    input  logic [IDX_W-1:0]  rs1,
    input  logic [IDX_W-1:0]  rs2,
    input  logic [IMM_W-1:0]  imm,
    input  logic [PC_W-1:0]   pc,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_fault,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              wb_valid,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [DATA_W-1:0] wb_data,
    output logic              wb_tok,
    output logic              redirect,
    output logic [PC_W-1:0]   redirect_pc,
    output logic              raise_exc,
    output logic [1:0]        exc_cause
);
    logic [DATA_W-1:0] a_data, b_data, wr_data;
    logic              a_tok, b_tok;
    logic [PC_W-1:0]   x_pc;
    ctl_s              ctl;

    dtt_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_rf (
        .clk(clk), .rst(rst),
        .ra_idx(rs1), .rb_idx(rs2),
        .ra_data(a_data), .ra_tok(a_tok),
        .rb_data(b_data), .rb_tok(b_tok),
        .w_en(ctl.wr_en), .w_idx(rd), .w_data(wr_data), .w_tok(ctl.wr_tok)
    );

    dtt_exec #(.NREG(NREG), .DATA_W(DATA_W), .IMM_W(IMM_W), .PC_W(PC_W)) u_ex (
        .op_valid(op_valid), .op_kind(op_kind), .alu_fn(alu_fn), .rd(rd),
        .imm(imm), .pc(pc),
        .a_data(a_data), .a_tok(a_tok), .b_data(b_data), .b_tok(b_tok),
        .mem_rdata(mem_rdata), .mem_fault(mem_fault),
        .ctl(ctl), .wr_data(wr_data), .mem_addr(mem_addr), .redir_pc(x_pc)
    );

    assign mem_wdata = b_data;
    assign mem_we    = ctl.st_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid    <= 1'b0;
            wb_idx      <= '0;
            wb_data     <= '0;
            wb_tok      <= 1'b0;
            redirect    <= 1'b0;
            redirect_pc <= '0;
            raise_exc   <= 1'b0;
            exc_cause   <= CAUSE_NONE;
        end else begin
            wb_valid    <= ctl.wr_en;
            wb_idx      <= rd;
            wb_data     <= wr_data;
            wb_tok      <= ctl.wr_tok;
            redirect    <= ctl.redir;
            redirect_pc <= x_pc;
            raise_exc   <= ctl.exc;
            exc_cause   <= ctl.cause;
        end
    end

    assert_exc_no_wb_R2: assert property (@(posedge clk) disable iff (rst)
        raise_exc |-> !wb_valid && !redirect);
    assert_tok_origin_R4: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && wb_tok) |-> ($past(op_kind) == 3'd2 || $past(op_kind) == 3'd3));
    assert_store_clean_R7: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !a_tok && !b_tok);
    assert_r0_no_wb_R8: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> wb_idx != '0);
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(op_valid) |-> !(wb_valid || redirect || raise_exc));
    assert_redir_src_R6: assert property (@(posedge clk) disable iff (rst)
        redirect |-> $past(op_kind) == 3'd4);
endmodule

// File: tb/tb_dtt_core.sv
module tb_dtt_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op_kind = '0;
    logic [1:0]  alu_fn = '0;
    logic [3:0]  rd = '0, rs1 = '0, rs2 = '0;
    logic [11:0] imm = '0;
    logic [31:0] pc = '0;
    logic [63:0] mem_rdata = '0;
    logic        mem_fault = 1'b0;
    logic [63:0] mem_addr, mem_wdata, wb_data;
    logic        mem_we, wb_valid, wb_tok, redirect, raise_exc;
    logic [3:0]  wb_idx;
    logic [31:0] redirect_pc;
    logic [1:0]  exc_cause;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] m_data [16];
    logic        m_tok  [16];

    dtt_core dut (.*);

    always #5 clk = ~clk;

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] alu_ref(input logic [1:0] f, input logic [63:0] a, input logic [63:0] b);
        case (f)
            2'd0: return a + b;
            2'd1: return a - b;
            2'd2: return a & b;
            default: return a ^ b;
        endcase
    endfunction

    task automatic run_op(input bit v, input logic [2:0] k, input logic [1:0] f,
                          input logic [3:0] d, input logic [3:0] s1, input logic [3:0] s2,
                          input logic [11:0] im, input logic [31:0] p,
                          input logic [63:0] rdat, input bit flt);
        logic [63:0] a, b, e_data, e_addr;
        logic ta, tb, e_wb, e_tok, e_red, e_exc, e_we;
        logic [1:0] e_cause;
        a  = (s1 == 0) ? 64'd0 : m_data[s1];
        ta = (s1 == 0) ? 1'b0  : m_tok[s1];
        b  = (s2 == 0) ? 64'd0 : m_data[s2];
        tb = (s2 == 0) ? 1'b0  : m_tok[s2];
        e_addr = a + {{52{im[11]}}, im};
        e_wb = 0; e_tok = 0; e_data = '0; e_red = 0; e_exc = 0; e_cause = 0; e_we = 0;
        if (v) begin
            case (k)
                3'd1: if (ta) begin e_exc = 1; e_cause = 2; end
                      else if (flt) begin e_exc = 1; e_cause = 1; end
                      else begin e_wb = 1; e_data = rdat; end
                3'd2: begin e_wb = 1; e_tok = ta | flt; e_data = rdat; end
                3'd3: begin e_wb = 1; e_tok = ta | tb; e_data = alu_ref(f, a, b); end
                3'd4: e_red = ta;
                3'd5: if (ta | tb) begin e_exc = 1; e_cause = 2; end else e_we = 1;
                default: ;
            endcase
        end
        if (d == 0) e_wb = 0;
        @(negedge clk);
        op_valid = v; op_kind = k; alu_fn = f; rd = d; rs1 = s1; rs2 = s2;
        imm = im; pc = p; mem_rdata = rdat; mem_fault = flt;
        #1;
        chk(mem_we === e_we, "R7 mem_we", 64'(mem_we), 64'(e_we));
        if (e_we) begin
            chk(mem_addr === e_addr, "R7 mem_addr", mem_addr, e_addr);
            chk(mem_wdata === b, "R7 mem_wdata", mem_wdata, b);
        end
        @(negedge clk);
        op_valid = 0;
        chk(wb_valid === e_wb, v ? "R5/R8 wb_valid" : "R9 wb_valid", 64'(wb_valid), 64'(e_wb));
        if (e_wb) begin
            chk(wb_idx === d, "R8 wb_idx", 64'(wb_idx), 64'(d));
            chk(wb_tok === e_tok, (k == 3'd3) ? "R4 wb_tok" : "R3/R10 wb_tok", 64'(wb_tok), 64'(e_tok));
            if (!e_tok) chk(wb_data === e_data, "R5 wb_data", wb_data, e_data);
        end
        chk(redirect === e_red, "R6 redirect", 64'(redirect), 64'(e_red));
        if (e_red) chk(redirect_pc === p + {{20{im[11]}}, im}, "R6 redirect_pc",
                       64'(redirect_pc), 64'(p + {{20{im[11]}}, im}));
        chk(raise_exc === e_exc, "R2/R7/R10 raise_exc", 64'(raise_exc), 64'(e_exc));
        if (e_exc) chk(exc_cause === e_cause, "R2/R7/R10 exc_cause", 64'(exc_cause), 64'(e_cause));
        if (e_wb) begin m_data[d] = e_data; m_tok[d] = e_tok; end
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) begin m_data[i] = '0; m_tok[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: outputs low after reset, all tokens clear
        chk(!wb_valid && !redirect && !raise_exc, "R1 outputs", {61'd0, wb_valid, redirect, raise_exc}, 64'd0);
        for (int r = 1; r < 16; r++) run_op(1, 3'd4, 0, 0, 4'(r), 0, 12'h010, 32'h1000, 0, 0);
        // R5 clean loads, R2 faulting load
        run_op(1, 3'd1, 0, 4'd1, 0, 0, 12'h020, 32'h0, 64'h1111_2222_3333_4444, 0);
        run_op(1, 3'd1, 0, 4'd2, 4'd1, 0, 12'hFF0, 32'h0, 64'h5, 1);
        run_op(1, 3'd1, 0, 4'd2, 0, 0, 12'h0, 32'h0, 64'h0000_0000_0000_0007, 0);
        // R3 speculative fault, R4 chain, R6 check with negative offset
        run_op(1, 3'd2, 0, 4'd3, 4'd1, 0, 12'h008, 32'h0, 64'hDEAD, 1);
        run_op(1, 3'd3, 2'd0, 4'd4, 4'd3, 4'd2, 0, 32'h0, 0, 0);
        run_op(1, 3'd3, 2'd3, 4'd5, 4'd2, 4'd4, 0, 32'h0, 0, 0);
        run_op(1, 3'd4, 0, 0, 4'd5, 0, 12'hF00, 32'h0000_2000, 0, 0);
        run_op(1, 3'd4, 0, 0, 4'd2, 0, 12'h100, 32'h0000_2000, 0, 0);
        // R7 poisoned and clean stores
        run_op(1, 3'd5, 0, 0, 4'd2, 4'd5, 12'h004, 32'h0, 0, 0);
        run_op(1, 3'd5, 0, 0, 4'd1, 4'd2, 12'hFFC, 32'h0, 0, 0);
        // R10 loads through a poisoned base
        run_op(1, 3'd1, 0, 4'd6, 4'd5, 0, 0, 32'h0, 64'h9, 0);
        run_op(1, 3'd2, 0, 4'd6, 4'd5, 0, 0, 32'h0, 64'h9, 0);
        // R5 clean overwrite clears token
        run_op(1, 3'd2, 0, 4'd5, 0, 0, 0, 32'h0, 64'hABCD, 0);
        run_op(1, 3'd4, 0, 0, 4'd5, 0, 12'h004, 32'h0, 0, 0);
        // R8 writes to register 0 dropped
        run_op(1, 3'd2, 0, 4'd0, 0, 0, 0, 32'h0, 64'h77, 1);
        run_op(1, 3'd4, 0, 0, 4'd0, 0, 12'h004, 32'h0, 0, 0);
        run_op(1, 3'd5, 0, 0, 4'd0, 4'd0, 0, 32'h0, 0, 0);
        // R9 invalid op has no effect
        run_op(0, 3'd2, 0, 4'd7, 0, 0, 0, 32'h0, 64'h1, 1);
        run_op(1, 3'd4, 0, 0, 4'd7, 0, 12'h004, 32'h0, 0, 0);
        run_op(1, 3'd6, 0, 4'd7, 0, 0, 0, 32'h0, 0, 1);
        // random mix: R2..R10
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] k;
            k = 3'($urandom_range(0, 7));
            run_op(($urandom_range(0, 15) != 0), k, 2'($urandom), 4'($urandom_range(0, 7)),
                   4'($urandom_range(0, 7)), 4'($urandom_range(0, 7)), 12'($urandom), $urandom,
                   {$urandom, $urandom}, ($urandom_range(0, 3) == 0));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule